// File: doc/BRIEF.md
# Write-Only Serial Control Target

This block is a Standard-mode I2C target that only accepts writes. It sits on a fast system clock and oversamples the bus clock and data lines through synchronizers. It drives the data line only through an open-drain pull-down enable. The surrounding logic holds the actual control registers. The block hands it one write strobe per accepted data byte, carrying the register index and the byte value.

Every write transaction has three stages. The host first sends the target's address byte. It then sends a byte that loads an internal register pointer. One or more data bytes follow, and each goes to the register the pointer names. The pointer then steps forward by one. Two strap inputs set the two most significant bits of the address byte, so four targets can share a bus. Data bytes aimed past the last implemented register are still acknowledged, but no strobe is issued for them.

Top module: `i2c_wr_target`

## Requirements
- R1: After reset the block is idle: `sda_pull` is low and `wr_valid` is low.
- R2: The address byte that is accepted is {strap[1], strap[0], BASE_ADDR[4:0], 0}, where address byte bit 0 is the R/W bit and 0 means write. With the default base this gives 0x06, 0x46, 0x86 and 0xC6 for strap values 0 to 3.
- R3: An address byte that does not match R2, including the matching address with R/W = 1, is not acknowledged. No later byte is acknowledged or strobed until the next START.
- R4: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. Data bits are taken on the SCL rising edge, most significant bit first.
- R5: The block pulls SDA low for the whole ninth clock of every accepted byte: a matching address, the pointer byte and each data byte. It starts pulling only after an SCL falling edge and releases SDA after the ninth clock falls.
- R6: The first byte after an accepted address loads the pointer and produces no strobe. Each later data byte produces a strobe with `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R7: The pointer increments by one after every data byte, wrapping from 0xFF to 0x00, so that successive data bytes target successive registers.
- R8: A data byte whose pointer is NUM_REGS or greater is acknowledged but produces no strobe. The pointer still increments.
- R9: A repeated START at any point, including in the middle of a byte, drops the partial byte and returns the block to address reception.
- R10: A STOP releases SDA and makes the block ignore the bus until the next START.
- R11: `wr_valid` is a single-cycle pulse for each strobed data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap | input | 2 | Address straps; bit 1 sets address byte bit 7, bit 0 sets bit 6 |
| sda_pull | output | 1 | When high, the pad pulls SDA low |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_addr | output | 8 | Register index for the strobe |
| wr_data | output | 8 | Data byte for the strobe |

## Verification
The bench keeps the default parameters: a base address of 0x03, five implemented registers and two synchronizer stages. With only five registers, a single burst starting at pointer 4 crosses from strobed writes into acknowledged-but-dropped writes. A pointer of 0xFF reaches the wrap to register 0 after one byte. The bench drives all four strap values and checks acknowledge polarity on each ninth clock. It also checks repeated START mid-byte, the R/W bit set, and bus traffic after a STOP.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_item_t;

    // Straps replace the two top bits of the 8-bit address byte; R/W must be 0.
    function automatic logic [BYTE_W-1:0] match_byte(input logic [6:0] base,
                                                     input logic [1:0] strap);
        return {strap, base[4:0], 1'b0};
    endfunction
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond
    import i2cw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/i2cw_core.sv
module i2cw_core
    import i2cw_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR = 7'h03,
    parameter int         NUM_REGS  = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_ev_t  ev,
    input  logic [1:0] strap,
    output logic     sda_pull,
    output logic     wr_valid,
    output wr_item_t wr_item
);
    localparam logic [BYTE_W:0] LIMIT = (BYTE_W+1)'(NUM_REGS);

    phase_e            phase;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            ptr      <= '0;
            sda_pull <= 1'b0;
            wr_valid <= 1'b0;
            wr_item  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (ev.start) begin
                phase    <= PH_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                phase    <= PH_IDLE;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ev.scl_rise && cnt < 4'd8) begin
                    shreg <= {shreg[BYTE_W-2:0], ev.sda};
                    cnt   <= cnt + 4'd1;
                end else if (ev.scl_fall && cnt == 4'd8) begin
                    cnt <= 4'd9;
                    unique case (phase)
                        PH_ADDR: begin
                            if (shreg == match_byte(BASE_ADDR, strap)) begin
                                sda_pull <= 1'b1;
                                phase    <= PH_PTR;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        PH_PTR: begin
                            ptr      <= shreg;
                            sda_pull <= 1'b1;
                            phase    <= PH_DATA;
                        end
                        PH_DATA: begin
                            sda_pull <= 1'b1;
                            ptr      <= ptr + 1'b1;
                            if ({1'b0, ptr} < LIMIT) begin
                                wr_valid     <= 1'b1;
                                wr_item.addr <= ptr;
                                wr_item.data <= shreg;
                            end
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end else if (ev.scl_fall && cnt == 4'd9) begin
                    sda_pull <= 1'b0;
                    cnt      <= '0;
                end
            end
        end
    end

    AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(ev.scl_fall)); // R5
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_pull && phase == PH_IDLE)); // R10
    AST_START_REARM: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == PH_ADDR && cnt == 4'd0)); // R9
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid); // R11
    AST_STROBE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ({1'b0, wr_item.addr} < LIMIT)); // R8
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (ptr == wr_item.addr + 1'b1)); // R7
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2cw_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR   = 7'h03,
    parameter int         NUM_REGS    = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] strap,
    output logic       sda_pull,
    output logic       wr_valid,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    logic [1:0] pins_s;
    bus_ev_t    ev;
    wr_item_t   item;

    i2cw_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(pins_s)
    );

    i2cw_cond u_cond (
        .clk(clk), .rst(rst), .scl_s(pins_s[1]), .sda_s(pins_s[0]), .ev(ev)
    );

    i2cw_core #(.BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS)) u_core (
        .clk(clk), .rst(rst), .ev(ev), .strap(strap),
        .sda_pull(sda_pull), .wr_valid(wr_valid), .wr_item(item)
    );

    assign wr_addr = item.addr;
    assign wr_data = item.data;
endmodule

// File: tb/i2c_wr_target_test.sv
module i2c_wr_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 10;   // system cycles per SCL half period

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_low = 1'b0;
    logic [1:0] strap = 2'b00;
    logic       sda_pull, wr_valid;
    logic [7:0] wr_addr, wr_data;
    logic       sda_bus;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_q[$];
    logic prev_valid = 1'b0;

    assign sda_bus = !(sda_low || sda_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_wr_target uut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .strap(strap),
        .sda_pull(sda_pull), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    // Scoreboard monitor: every strobe must match the next expected item.
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                check(!prev_valid, "R11 strobe width", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected strobe", {wr_addr, wr_data}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check({wr_addr, wr_data} == e, "R6 strobe content", {wr_addr, wr_data}, e);
                end
            end
            prev_valid <= wr_valid;
        end
    end

    task automatic bus_start();
        sda_low = 1'b0; wait_cyc(HALF);
        scl_m = 1'b1;   wait_cyc(HALF);
        sda_low = 1'b1; wait_cyc(HALF);
        scl_m = 1'b0;   wait_cyc(HALF/2);
    endtask

    task automatic bus_stop();
        sda_low = 1'b1; wait_cyc(HALF);
        scl_m = 1'b1;   wait_cyc(HALF);
        sda_low = 1'b0; wait_cyc(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_low = !b[i]; wait_cyc(HALF);
            scl_m = 1'b1;    wait_cyc(HALF);
            scl_m = 1'b0;    wait_cyc(HALF/2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        send_bits(b, 8);
        sda_low = 1'b0; wait_cyc(HALF);
        scl_m = 1'b1;   wait_cyc(HALF/2);
        check((!sda_bus) == exp_ack, req, !sda_bus, exp_ack);
        wait_cyc(HALF/2);
        scl_m = 1'b0;   wait_cyc(HALF/2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
        // R1 reset state
        check(sda_pull == 1'b0, "R1 sda_pull", sda_pull, 0);
        check(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);

        // R2/R5/R6/R7: straps 00, burst to registers 1 and 2
        strap = 2'b00;
        bus_start();
        send_byte(8'h06, 1, "R2 addr 0x06");
        send_byte(8'h01, 1, "R5 ack ptr");
        expect_wr(8'h01, 8'hA5);
        send_byte(8'hA5, 1, "R5 ack data");
        expect_wr(8'h02, 8'h3C);
        send_byte(8'h3C, 1, "R7 ack second data");
        bus_stop();
        wait_cyc(8);
        check(sda_pull == 1'b0, "R10 released after stop", sda_pull, 0);

        // R8: strap 10 -> 0x86, run past last register
        strap = 2'b10;
        bus_start();
        send_byte(8'h86, 1, "R2 addr 0x86");
        send_byte(8'h04, 1, "R6 ptr 4");
        expect_wr(8'h04, 8'h11);
        send_byte(8'h11, 1, "R7 data reg4");
        send_byte(8'h22, 1, "R8 ack out of range 5");
        send_byte(8'h33, 1, "R8 ack out of range 6");
        bus_stop();

        // R3: mismatch and read bit
        strap = 2'b01;
        bus_start();
        send_byte(8'h06, 0, "R3 nack wrong addr");
        send_byte(8'h00, 0, "R3 nack after mismatch");
        send_byte(8'h55, 0, "R3 no strobe after mismatch");
        bus_stop();
        bus_start();
        send_byte(8'h47, 0, "R3 nack read bit");
        send_byte(8'h00, 0, "R3 nack after read");
        bus_stop();
        bus_start();
        send_byte(8'h46, 1, "R2 addr 0x46");
        send_byte(8'h00, 1, "R6 ptr 0");
        expect_wr(8'h00, 8'hE7);
        send_byte(8'hE7, 1, "R6 data reg0");
        bus_stop();

        // R7 wrap: strap 11 -> 0xC6, pointer 0xFF
        strap = 2'b11;
        bus_start();
        send_byte(8'hC6, 1, "R2 addr 0xC6");
        send_byte(8'hFF, 1, "R6 ptr ff");
        send_byte(8'h77, 1, "R8 ack at ff");
        expect_wr(8'h00, 8'h88);
        send_byte(8'h88, 1, "R7 wrap to reg0");
        bus_stop();

        // R9: repeated START mid-byte and after address
        bus_start();
        send_byte(8'hC6, 1, "R9 addr before abort");
        send_byte(8'h02, 1, "R9 ptr before abort");
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(8'hC6, 1, "R9 addr after repeated start");
        bus_start();
        send_byte(8'hC6, 1, "R9 addr after second repeated start");
        send_byte(8'h03, 1, "R9 ptr after restart");
        expect_wr(8'h03, 8'h5A);
        send_byte(8'h5A, 1, "R9 data after restart");
        bus_stop();

        // R4/R10: STOP mid-transaction, then clocks without START are ignored
        bus_start();
        send_byte(8'hC6, 1, "R4 addr");
        send_byte(8'h00, 1, "R4 ptr");
        bus_stop();
        scl_m = 1'b0; wait_cyc(HALF);
        send_byte(8'h99, 0, "R10 ignored after stop");
        send_byte(8'hC6, 0, "R4 address without start ignored");
        sda_low = 1'b0; wait_cyc(HALF);
        scl_m = 1'b1; wait_cyc(4 * HALF);

        check(exp_q.size() == 0, "R6 all expected strobes seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule